// File: doc/BRIEF.md
# Deep Power-Down Controller for a Serial Memory Slave

This block follows the low-power sleep state of a serial memory slave. It runs on the system clock. It watches three things from the front end of the slave: the chip-select level, a one-cycle pulse for each serial-clock edge, and the opcode that the command decoder reports once it has shifted in a full opcode byte.

When the sleep opcode is followed directly by the deselect edge, the controller puts the slave to sleep. If any serial-clock edge arrives between the opcode and the deselect, the request is dropped. While the slave sleeps, the controller holds the command engine disabled and the serial output released, and it ignores all serial traffic.

A select edge wakes the slave. The controller then counts a recovery window in system-clock cycles. During that window the command engine stays blocked and a busy flag is raised. If the slave is selected a second time inside the window, a sticky violation flag is set and the count starts over. When the window has run out, the engine is enabled again and a one-cycle pulse clears the write-enable latch.

Top module: `deep_pd_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `asleep`=0, `engine_en`=1, `so_disable`=0, `recov_busy`=0, `wel_clear`=0, `recov_violation`=0.
- R2: The slave goes to sleep when opcode 0xBA is reported while `cs_n` is low and `cs_n` then rises with no serial-clock edge in between. `asleep` reads 1 from the cycle after the cycle in which the rise is sampled.
- R3: A serial-clock pulse after the 0xBA opcode cancels the sleep request. This includes a pulse in the same cycle as the `cs_n` rise. After the deselect, `asleep` stays 0.
- R4: An opcode other than 0xBA never causes sleep. A later opcode that is not 0xBA also cancels an earlier 0xBA.
- R5: While asleep, the outputs are `engine_en`=0, `so_disable`=1 and `recov_busy`=0. Serial-clock pulses, reported opcodes and `cs_n` rises leave this state unchanged.
- R6: A fall of `cs_n` while asleep starts recovery. From the cycle after that fall, `recov_busy` is 1 for exactly RECOVERY_CYCLES cycles, `asleep` is 0, `engine_en` is 0 and `so_disable` is 1. After that the block is awake.
- R7: `cs_n` may rise during recovery. This neither shortens nor extends the window and does not set the violation flag.
- R8: A fall of `cs_n` during recovery sets `recov_violation`, which stays set until reset. It also restarts the full window. This holds even when the fall lands in the last counted cycle, and in that case no wake happens that cycle.
- R9: `wel_clear` is a single-cycle pulse in the first awake cycle after recovery. It is 0 at every other time.
- R10: Opcodes reported during recovery are discarded. A 0xBA seen in recovery does not let a later deselect cause sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, already synchronous to clk |
| sck_edge | input | 1 | One-cycle pulse per serial-clock edge |
| op_valid | input | 1 | Pulse: a full opcode byte has been decoded |
| op_code | input | OP_W | Opcode qualified by op_valid |
| asleep | output | 1 | Slave is in deep power-down |
| engine_en | output | 1 | Command engine may run |
| so_disable | output | 1 | Serial output must be high-impedance |
| recov_busy | output | 1 | Wake-up recovery window running |
| wel_clear | output | 1 | One-cycle clear of the write-enable latch |
| recov_violation | output | 1 | Sticky: select fell during recovery |

## Verification
Two pairs of events can fall in the same cycle, and each pair must resolve in one fixed way.

The first pair is the recovery counter expiring and a fresh `cs_n` fall. The bench lowers chip select exactly in the cycle where the window would end. It then expects busy to stay high, the violation flag to be set, no write-enable clear, and a second full window.

The second pair is a serial-clock pulse and the deselect edge that would otherwise cause sleep. The bench drives both in one cycle and expects the slave to stay awake.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    PD_AWAKE   = 2'd0,
    PD_SLEEP   = 2'd1,
    PD_RECOVER = 2'd2
  } pd_state_e;
endpackage

// File: rtl/pd_cs_edge.sv
// Chip-select edge detector: compares the live level with last cycle's level.
module pd_cs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic cs_rise,
  output logic cs_fall
);
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  always_comb begin
    cs_rise = cs_n & ~cs_q;
    cs_fall = ~cs_n & cs_q;
  end
endmodule

// File: rtl/pd_entry_arm.sv
// Holds the pending sleep request between the opcode and the deselect edge.
module pd_entry_arm #(
  parameter int unsigned          OP_W  = 8,
  parameter logic [OP_W-1:0]      PD_OP = 8'hBA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            cs_low,
  input  logic            cs_rise,
  input  logic            sck_edge,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  output logic            armed
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (!enable || cs_rise)        armed_d = 1'b0;
    else if (op_valid && cs_low)   armed_d = (op_code == PD_OP);
    else if (sck_edge)             armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign armed = armed_q;

  // R3: a serial-clock edge seen while armed cancels the request
  a_r3_sck_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && sck_edge && !op_valid) |=> !armed_q);
endmodule

// File: rtl/pd_recovery_timer.sv
// Down-counter for the wake-up recovery window.
module pd_recovery_timer #(
  parameter int unsigned CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic zero
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                      cnt_d = LOAD_VAL;
    else if (run && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R6: a running count only moves downward or holds at zero
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/deep_pd_ctrl.sv
module deep_pd_ctrl
  import pd_pkg::*;
#(
  parameter int unsigned     OP_W            = 8,
  parameter logic [OP_W-1:0] PD_OP           = 8'hBA,
  parameter int unsigned     RECOVERY_CYCLES = 2500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sck_edge,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  output logic            asleep,
  output logic            engine_en,
  output logic            so_disable,
  output logic            recov_busy,
  output logic            wel_clear,
  output logic            recov_violation
);
  pd_state_e state_q, state_d;
  logic      cs_rise, cs_fall;
  logic      armed, enter;
  logic      tmr_load, tmr_run, tmr_zero;
  logic      viol_q, viol_d;
  logic      wel_q, wel_d;

  pd_cs_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .cs_rise (cs_rise),
    .cs_fall (cs_fall)
  );

  pd_entry_arm #(.OP_W(OP_W), .PD_OP(PD_OP)) u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (state_q == PD_AWAKE),
    .cs_low   (~cs_n),
    .cs_rise  (cs_rise),
    .sck_edge (sck_edge),
    .op_valid (op_valid),
    .op_code  (op_code),
    .armed    (armed)
  );

  pd_recovery_timer #(.CYCLES(RECOVERY_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .run   (tmr_run),
    .zero  (tmr_zero)
  );

  // Sleep is entered only if no serial-clock edge shares the deselect cycle.
  assign enter    = (state_q == PD_AWAKE) && armed && cs_rise && !sck_edge;
  assign tmr_load = (state_q != PD_AWAKE) && cs_fall;
  assign tmr_run  = (state_q == PD_RECOVER);

  always_comb begin
    state_d = state_q;
    viol_d  = viol_q;
    wel_d   = 1'b0;
    unique case (state_q)
      PD_AWAKE:   if (enter) state_d = PD_SLEEP;
      PD_SLEEP:   if (cs_fall) state_d = PD_RECOVER;
      PD_RECOVER: begin
        if (cs_fall) begin
          viol_d = 1'b1;
        end else if (tmr_zero) begin
          state_d = PD_AWAKE;
          wel_d   = 1'b1;
        end
      end
      default:    state_d = PD_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PD_AWAKE;
      viol_q  <= 1'b0;
      wel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      viol_q  <= viol_d;
      wel_q   <= wel_d;
    end
  end

  assign asleep          = (state_q == PD_SLEEP);
  assign engine_en       = (state_q == PD_AWAKE);
  assign so_disable      = (state_q != PD_AWAKE);
  assign recov_busy      = (state_q == PD_RECOVER);
  assign wel_clear       = wel_q;
  assign recov_violation = viol_q;

  // R2: sleep begins only right after a deselect edge
  a_r2_entry_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !$past(asleep)) |-> $past(cs_rise));
  // R5: without a select edge the sleep state persists
  a_r5_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !cs_fall) |=> asleep);
  // R8: the violation flag never clears
  a_r8_violation_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    recov_violation |=> recov_violation);
  // R9: the latch clear is one cycle long and follows recovery
  a_r9_wel_single: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clear |=> !wel_clear);
  a_r9_wel_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clear |-> ($past(recov_busy) && engine_en));
endmodule

// File: tb/deep_pd_ctrl_bench.sv
`timescale 1ns/1ps
module deep_pd_ctrl_bench;
  localparam int RC = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, sck_edge, op_valid;
  logic [7:0] op_code;
  logic       asleep, engine_en, so_disable, recov_busy, wel_clear, recov_violation;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  deep_pd_ctrl #(.OP_W(8), .PD_OP(8'hBA), .RECOVERY_CYCLES(RC)) u_deep_pd_ctrl (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sck_edge (sck_edge),
    .op_valid (op_valid), .op_code (op_code), .asleep (asleep),
    .engine_en (engine_en), .so_disable (so_disable), .recov_busy (recov_busy),
    .wel_clear (wel_clear), .recov_violation (recov_violation)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_op(input logic [7:0] code);
    op_valid = 1'b1; op_code = code;
    step();
    op_valid = 1'b0;
  endtask

  task automatic do_enter();
    cs_n = 1'b0; step();
    send_op(8'hBA);
    cs_n = 1'b1; step();
  endtask

  task automatic t_reset();
    check("R1 asleep", asleep, 0);
    check("R1 engine_en", engine_en, 1);
    check("R1 so_disable", so_disable, 0);
    check("R1 busy", recov_busy, 0);
    check("R1 wel_clear", wel_clear, 0);
    check("R1 violation", recov_violation, 0);
  endtask

  task automatic t_enter_and_wake();
    do_enter();
    check("R2 asleep after deselect", asleep, 1);
    check("R5 engine off", engine_en, 0);
    check("R5 so off", so_disable, 1);
    cs_n = 1'b0; step();
    check("R6 busy after fall", recov_busy, 1);
    check("R6 not asleep", asleep, 0);
    check("R6 engine off", engine_en, 0);
    check("R6 so off", so_disable, 1);
    repeat (RC - 1) step();
    check("R6 busy last cycle", recov_busy, 1);
    check("R9 no early clear", wel_clear, 0);
    step();
    check("R6 awake after window", recov_busy, 0);
    check("R6 engine back", engine_en, 1);
    check("R9 clear pulse", wel_clear, 1);
    step();
    check("R9 pulse ends", wel_clear, 0);
    cs_n = 1'b1; step();
    check("R7 no violation", recov_violation, 0);
  endtask

  task automatic t_cancel_gap();
    cs_n = 1'b0; step();
    send_op(8'hBA);
    sck_edge = 1'b1; step();
    sck_edge = 1'b0; cs_n = 1'b1; step();
    check("R3 cancelled by sck", asleep, 0);
  endtask

  task automatic t_cancel_same_cycle();
    cs_n = 1'b0; step();
    send_op(8'hBA);
    cs_n = 1'b1; sck_edge = 1'b1; step();
    sck_edge = 1'b0;
    check("R3 sck with deselect cancels", asleep, 0);
    check("R3 engine still on", engine_en, 1);
  endtask

  task automatic t_other_opcodes();
    cs_n = 1'b0; step();
    send_op(8'h06);
    cs_n = 1'b1; step();
    check("R4 other opcode", asleep, 0);
    cs_n = 1'b0; step();
    send_op(8'hBA);
    send_op(8'h05);
    cs_n = 1'b1; step();
    check("R4 later opcode overrides", asleep, 0);
  endtask

  task automatic t_sleep_ignores();
    do_enter();
    sck_edge = 1'b1; step(); sck_edge = 1'b0;
    send_op(8'hBA);
    send_op(8'h03);
    step();
    check("R5 asleep held", asleep, 1);
    check("R5 engine off", engine_en, 0);
    check("R5 so off", so_disable, 1);
    check("R5 not busy", recov_busy, 0);
    cs_n = 1'b0; step();
    repeat (RC) step();
    check("R5 wakes normally", engine_en, 1);
    cs_n = 1'b1; step();
  endtask

  task automatic t_rise_in_recovery();
    do_enter();
    cs_n = 1'b0; step();
    cs_n = 1'b1; step();
    repeat (RC - 3) step();
    check("R7 busy still", recov_busy, 1);
    step();
    check("R7 window length kept", recov_busy, 1);
    step();
    check("R7 awake on time", recov_busy, 0);
    check("R7 no violation", recov_violation, 0);
  endtask

  task automatic t_recovery_opcode();
    do_enter();
    cs_n = 1'b0; step();
    send_op(8'hBA);
    repeat (RC - 2) step();
    step();
    check("R10 awake", engine_en, 1);
    cs_n = 1'b1; step();
    check("R10 opcode in recovery discarded", asleep, 0);
  endtask

  task automatic t_violation();
    do_enter();
    cs_n = 1'b0; step();
    repeat (3) step();
    cs_n = 1'b1; step();
    cs_n = 1'b0; step();
    check("R8 violation set", recov_violation, 1);
    check("R8 still busy", recov_busy, 1);
    repeat (RC - 1) step();
    check("R8 window restarted", recov_busy, 1);
    step();
    check("R8 awake after restart", recov_busy, 0);
    cs_n = 1'b1; step();
  endtask

  task automatic t_violation_at_expiry();
    do_enter();
    cs_n = 1'b0; step();
    cs_n = 1'b1; step();
    repeat (RC - 2) step();
    cs_n = 1'b0; step();
    check("R8 fall at expiry keeps busy", recov_busy, 1);
    check("R9 no clear on collision", wel_clear, 0);
    check("R8 violation sticky", recov_violation, 1);
    repeat (RC - 1) step();
    check("R8 second window full", recov_busy, 1);
    step();
    check("R8 awake after second window", recov_busy, 0);
    check("R9 clear after second window", wel_clear, 1);
    cs_n = 1'b1; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck_edge = 1'b0; op_valid = 1'b0; op_code = 8'h00;
    repeat (3) step();
    rst_n = 1'b1; step();
    t_reset();
    t_enter_and_wake();
    t_cancel_gap();
    t_cancel_same_cycle();
    t_other_opcodes();
    t_sleep_ignores();
    t_rise_in_recovery();
    t_recovery_opcode();
    t_violation();
    t_violation_at_expiry();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule